// File: doc/BRIEF.md
# Dual-Port Address-Collision Arbiter

This block is a clocked arbitration unit that sits in front of a true dual-port memory array. The array has a left and a right port, and each port presents a chip enable, a write strobe and an address. Every cycle the unit compares the two addresses. When both ports are enabled on the same location, it decides which port wins and raises a busy flag to the losing port. It also produces, for each port, a qualified write enable that the memory array uses in place of the raw strobe.

A mode input makes one design serve either role in a width-expanded group. In master mode the unit arbitrates itself and drives its busy outputs. In slave mode the busy outputs stay low, because those pins act as inputs, and the busy inputs carry the master's decision. An asserted busy input stops the write on that port. The busy flag and the qualified write enable are both registered, so they change together, one cycle after the inputs that cause them.

Top module: `dpa_collision_arbiter`

## Requirements
- R1: After reset, `l_busy`, `r_busy`, `l_wr_ok` and `r_wr_ok` are all 0.
- R2: In master mode (`master_mode`=1), when both ports become enabled on the same address in the same cycle, the left port wins. One cycle later `r_busy`=1 and `l_busy`=0.
- R3: In master mode, when the right port is already enabled on an address and the left port moves its address onto that address, the left port is flagged. One cycle later `l_busy`=1.
- R4: In master mode, when one port is already enabled on an address and the other port asserts its chip enable with that same address already presented, the port that just enabled is flagged busy one cycle later.
- R5: A winning port keeps ownership for as long as the match lasts. If the losing port leaves the address and then comes back while the winner has stayed, the returning port is flagged again.
- R6: Busy falls to 0 one cycle after the addresses stop matching or either chip enable falls.
- R7: The qualified write enable of a port is 1 one cycle after a cycle in which that port had both chip enable and write strobe high and was not the port losing arbitration. In master mode the port flagged busy never has its write enabled.
- R8: In slave mode (`master_mode`=0), `l_busy` and `r_busy` stay 0. A port whose busy input is 1 gets a qualified write enable of 0 in the next cycle, while the other port's write is unaffected.
- R9: In slave mode a same-address collision blocks no write by itself. Only the busy inputs gate the writes.
- R10: When the two enabled ports present different addresses, neither port is flagged busy and both writes pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = obey busy inputs |
| l_ce | input | 1 | Left chip enable, active high |
| l_we | input | 1 | Left write strobe, active high |
| l_addr | input | ADDR_W | Left address |
| l_busy_in | input | 1 | Left busy from the master (slave mode) |
| r_ce | input | 1 | Right chip enable, active high |
| r_we | input | 1 | Right write strobe, active high |
| r_addr | input | ADDR_W | Right address |
| r_busy_in | input | 1 | Right busy from the master (slave mode) |
| l_busy | output | 1 | Registered busy flag to the left port |
| r_busy | output | 1 | Registered busy flag to the right port |
| l_wr_ok | output | 1 | Registered qualified left write enable |
| r_wr_ok | output | 1 | Registered qualified right write enable |

## Verification
The hardest case to reach from the ports is a match that forms while one port already holds the address. The winner then depends on which side was present the cycle before, and that history is not visible at the ports. The stimulus builds this case in three ways: by moving an address onto a held location, by raising a chip enable onto an address already presented, and by having the loser leave and come back while the winner stays put. The behavioural model in the bench tracks each port's previous enable and address, and the checks compare all four outputs against it on every cycle.

// File: rtl/dpa_pkg.sv
`timescale 1ns/1ps
package dpa_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Ownership rule: no match clears, an existing owner is kept,
  // a fresh match goes to the side that was already there (left on a tie).
  function automatic owner_e f_next_owner(input logic   match,
                                          input logic   l_stay,
                                          input logic   r_stay,
                                          input owner_e cur);
    owner_e nxt;
    if (!match)                nxt = OWN_NONE;
    else if (cur != OWN_NONE)  nxt = cur;
    else if (r_stay && !l_stay) nxt = OWN_RIGHT;
    else                       nxt = OWN_LEFT;
    return nxt;
  endfunction

  function automatic logic f_addr_hit(input logic a_ce, input logic b_ce,
                                      input logic [63:0] a, input logic [63:0] b);
    return a_ce && b_ce && (a == b);
  endfunction

endpackage

// File: rtl/dpa_port_track.sv
`timescale 1ns/1ps
// Remembers what a port presented last cycle, to tell a port that
// stayed on its address from one that just arrived.
module dpa_port_track #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [ADDR_W-1:0] addr,
  output logic              stay
);
  logic              ce_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      ce_q   <= ce;
      addr_q <= addr;
    end
  end

  assign stay = ce_q && (addr_q == addr);
endmodule

// File: rtl/dpa_owner.sv
`timescale 1ns/1ps
module dpa_owner
  import dpa_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   match,
  input  logic   l_stay,
  input  logic   r_stay,
  output owner_e owner_q,
  output logic   l_lose,
  output logic   r_lose
);
  owner_e owner_d;

  assign owner_d = f_next_owner(match, l_stay, r_stay, owner_q);
  assign l_lose  = (owner_d == OWN_RIGHT);
  assign r_lose  = (owner_d == OWN_LEFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_d;
  end

  // R6: no match this cycle means no owner next cycle
  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !match |=> owner_q == OWN_NONE);

  // R5: an owner holds while the match lasts
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match && owner_q != OWN_NONE) |=> owner_q == $past(owner_q));

  // R3: right already there, left arrives -> right owns
  p_first_come_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (match && owner_q == OWN_NONE && r_stay && !l_stay) |=> owner_q == OWN_RIGHT);
endmodule

// File: rtl/dpa_write_gate.sv
`timescale 1ns/1ps
module dpa_write_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic master_mode,
  input  logic ce,
  input  logic we,
  input  logic lose,
  input  logic busy_in,
  output logic wr_ok
);
  logic block;
  assign block = master_mode ? lose : busy_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ok <= 1'b0;
    else        wr_ok <= ce && we && !block;
  end

  // R8: slave busy input kills the write
  p_slave_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && busy_in) |=> !wr_ok);
endmodule

// File: rtl/dpa_collision_arbiter.sv
`timescale 1ns/1ps
module dpa_collision_arbiter
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy_in,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy_in,
  output logic              l_busy,
  output logic              r_busy,
  output logic              l_wr_ok,
  output logic              r_wr_ok
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]             ce_v, we_v, busy_in_v, stay_v, lose_v, wr_v;
  logic [NPORT-1:0][ADDR_W-1:0] addr_v;
  logic                         addr_match;
  owner_e                       owner_q;

  assign ce_v      = {r_ce, l_ce};
  assign we_v      = {r_we, l_we};
  assign busy_in_v = {r_busy_in, l_busy_in};
  assign addr_v    = {r_addr, l_addr};

  assign addr_match = f_addr_hit(l_ce, r_ce, 64'(l_addr), 64'(r_addr));

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk  (clk),
      .rst_n(rst_n),
      .ce   (ce_v[p]),
      .addr (addr_v[p]),
      .stay (stay_v[p])
    );
    dpa_write_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .master_mode(master_mode),
      .ce         (ce_v[p]),
      .we         (we_v[p]),
      .lose       (lose_v[p]),
      .busy_in    (busy_in_v[p]),
      .wr_ok      (wr_v[p])
    );
  end

  dpa_owner u_owner (
    .clk    (clk),
    .rst_n  (rst_n),
    .match  (addr_match),
    .l_stay (stay_v[0]),
    .r_stay (stay_v[1]),
    .owner_q(owner_q),
    .l_lose (lose_v[0]),
    .r_lose (lose_v[1])
  );

  assign l_busy  = master_mode && (owner_q == OWN_RIGHT);
  assign r_busy  = master_mode && (owner_q == OWN_LEFT);
  assign l_wr_ok = wr_v[0];
  assign r_wr_ok = wr_v[1];

  // R7: a flagged master port never writes in the same cycle
  p_loser_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && l_busy) |-> !l_wr_ok);
  p_loser_nowrite_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && r_busy) |-> !r_wr_ok);
endmodule

// File: tb/dpa_collision_arbiter_tb.sv
`timescale 1ns/1ps
module dpa_collision_arbiter_tb;
  localparam int AW = 14;

  logic clk = 0, rst_n = 0, master_mode = 1;
  logic l_ce = 0, l_we = 0, l_bi = 0, r_ce = 0, r_we = 0, r_bi = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy, r_busy, l_wr_ok, r_wr_ok;

  int errors = 0, checks = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural model state
  int owner = 0;            // 0 none, 1 left, 2 right
  bit p_lce = 0, p_rce = 0;
  int p_la = 0, p_ra = 0;
  bit e_lb = 0, e_rb = 0, e_lw = 0, e_rw = 0;

  always #5 clk = ~clk;

  dpa_collision_arbiter #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr), .l_busy_in(l_bi),
    .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr), .r_busy_in(r_bi),
    .l_busy(l_busy), .r_busy(r_busy), .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner = 0; p_lce = 0; p_rce = 0; p_la = 0; p_ra = 0;
      e_lb = 0; e_rb = 0; e_lw = 0; e_rw = 0;
    end else begin
      bit hit, ls, rs;
      hit = l_ce && r_ce && (l_addr == r_addr);
      ls = p_lce && (p_la == int'(l_addr));
      rs = p_rce && (p_ra == int'(r_addr));
      if (!hit) owner = 0;
      else if (owner == 0) owner = (rs && !ls) ? 2 : 1;
      e_lb = master_mode && owner == 2;
      e_rb = master_mode && owner == 1;
      e_lw = l_ce && l_we && !(master_mode ? (owner == 2) : l_bi);
      e_rw = r_ce && r_we && !(master_mode ? (owner == 1) : r_bi);
      p_lce = l_ce; p_rce = r_ce; p_la = int'(l_addr); p_ra = int'(r_addr);
    end
  end

  task automatic chk(string what, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("l_busy", l_busy, e_lb);
    chk("r_busy", r_busy, e_rb);
    chk("l_wr_ok", l_wr_ok, e_lw);
    chk("r_wr_ok", r_wr_ok, e_rw);
  end

  task automatic drive(bit lc, bit lw, int la, bit rc, bit rw, int ra,
                       bit lb = 0, bit rb = 0);
    l_ce = lc; l_we = lw; l_addr = AW'(la);
    r_ce = rc; r_we = rw; r_addr = AW'(ra);
    l_bi = lb; r_bi = rb;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          errors++;
          $display("FAIL watchdog expired");
          $display("Result: errors=%0d of %0d checks", errors, checks);
          $finish;
        end
      end
    join_none

    // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);

    tag = "R10";  // different addresses
    drive(1, 1, 5, 1, 1, 6);
    drive(1, 1, 7, 1, 1, 8);
    idle(1);

    tag = "R2";   // simultaneous arrival, left wins
    drive(1, 1, 20, 1, 1, 20);
    drive(1, 1, 20, 1, 1, 20);
    tag = "R6";   // right CE drops
    drive(1, 1, 20, 0, 1, 20);
    drive(1, 1, 20, 0, 0, 20);
    idle(1);

    tag = "R3";   // right holds, left moves onto it
    drive(0, 0, 0, 1, 1, 33);
    drive(1, 1, 34, 1, 1, 33);
    drive(1, 1, 33, 1, 1, 33);
    drive(1, 1, 33, 1, 1, 33);
    tag = "R6";   // address mismatch drops busy
    drive(1, 1, 34, 1, 1, 33);
    idle(1);

    tag = "R4";   // left CE rises onto held address
    drive(0, 1, 9, 1, 0, 9);
    drive(1, 1, 9, 1, 0, 9);
    drive(1, 1, 9, 1, 0, 9);
    tag = "R4";   // right CE rises onto held left address
    drive(1, 0, 12, 0, 1, 12);
    drive(1, 0, 12, 1, 1, 12);
    drive(1, 0, 12, 1, 1, 12);
    idle(1);

    tag = "R5";   // winner stays, loser leaves and returns
    drive(1, 1, 3, 1, 1, 3);
    drive(1, 1, 3, 1, 1, 3);
    drive(1, 1, 3, 1, 1, 4);
    drive(1, 1, 3, 1, 1, 3);
    drive(1, 1, 3, 1, 1, 3);
    tag = "R6";   // left CE drops
    drive(0, 1, 3, 1, 1, 3);
    idle(1);

    tag = "R7";   // read on the winning side, write on the loser
    drive(1, 0, 40, 1, 1, 40);
    drive(1, 0, 40, 1, 1, 40);
    drive(1, 1, 40, 0, 1, 40);
    idle(2);

    // slave mode
    done = 1;
    rst_n = 0; master_mode = 0;
    @(negedge clk);
    done = 0;
    tag = "R1";
    rst_n = 1;
    idle(1);

    tag = "R8";
    drive(1, 1, 1, 1, 1, 2, 1, 0);
    drive(1, 1, 1, 1, 1, 2, 0, 1);
    drive(1, 1, 1, 1, 1, 2, 1, 1);
    drive(1, 1, 1, 1, 1, 2, 0, 0);
    tag = "R9";
    drive(1, 1, 50, 1, 1, 50);
    drive(1, 1, 50, 1, 1, 50);
    drive(1, 1, 50, 1, 1, 50, 0, 1);
    idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule